// File: doc/BRIEF.md
# Bang-Bang Coarse Lock Controller

This block steers a digitally tuned ring oscillator toward lock during the coarse acquisition phase of a digital PLL. A phase detector supplies one bit per reference-derived clock, telling the block whether the oscillator code should rise or fall. The block moves an internal up/down code by one step per clock in that direction, saturating at both ends of the tuning range. While the loop hunts around the correct frequency, the code traces a limit cycle.

The block records each turning point of that limit cycle. A peak is the code at which the direction flips from rising to falling. A trough is the code at which it flips from falling to rising. The block keeps the two newest peaks and the two newest troughs. When either pair lies within a small window, the block freezes the code at the midpoint of the newest peak and trough. It then raises a fine-enable flag, which hands control to a later fine-tuning stage. The selected code is presented split into a row select (high bits) and a column select (low bits). These drive the oscillator's inverter array directly.

Top module: `coarse_lock_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the block clears `fine_en`, loads the code to mid-scale (MAX_CODE/2 = 12 by default) and forgets all stored peaks and troughs.
- R2: While `fine_en` is low, each clock edge moves the code by exactly one: up when `sign_up` is 1, down when it is 0.
- R3: The code saturates at 0 and at MAX_CODE (24 by default), and it never wraps.
- R4: A peak is recorded when `sign_up` is 0 at an edge and was 1 at the previous coarse edge. A trough is recorded on the opposite change. The value recorded is the code held just before that edge.
- R5: Only the two most recent peaks and the two most recent troughs are kept. A new capture discards the oldest one.
- R6: No lock is declared until at least two peaks and two troughs have been recorded since reset.
- R7: When the two stored peaks, or the two stored troughs, differ by at most LOCK_WIN (2), `fine_en` goes high at the next clock edge. A difference of 3 does not lock.
- R8: From the edge at which `fine_en` rises, the code becomes floor((newest peak + newest trough) / 2).
- R9: Once `fine_en` is high, it stays high and the code stays fixed, whatever `sign_up` does, until reset.
- R10: `row_sel` is code bits [CODE_W-1:COL_W] and `col_sel` is code bits [COL_W-1:0]; with defaults, code = 8*row_sel + col_sel.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference-derived controller clock |
| rst | input | 1 | Synchronous active-high reset |
| sign_up | input | 1 | Phase detector decision, 1 = raise code |
| fine_en | output | 1 | Coarse lock reached, fine tuning enabled |
| row_sel | output | CODE_W-COL_W (2) | High part of selected code |
| col_sel | output | COL_W (3) | Low part of selected code |

## Verification
The code is visible at the ports on every cycle. A wrong step or a wrong saturation point therefore shows up at the next edge as a mismatch against the model. A peak or trough captured with the wrong value, or pushed into the wrong slot, stays hidden until the lock decision. It then appears either as a lock on the wrong edge, or as the wrong frozen midpoint on the first locked cycle. The directed limit cycles are therefore built so that each stored extreme decides either the lock timing or the midpoint. Random hunting sequences add coverage of saturation during a swing.

// File: rtl/coarse_lock_pkg.sv
package coarse_lock_pkg;
  // absolute difference of two small unsigned codes
  function automatic int unsigned code_gap(input int unsigned a, input int unsigned b);
    return (a > b) ? (a - b) : (b - a);
  endfunction

  typedef struct packed {
    logic peak;
    logic trough;
  } turn_t;
endpackage

// File: rtl/cl_step_counter.sv
module cl_step_counter #(
  parameter int MAX_CODE = 24,
  parameter int CODE_W   = 5,
  parameter int RST_CODE = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              adv,
  input  logic              up,
  output logic [CODE_W-1:0] cnt
);
  localparam logic [CODE_W-1:0] TOP  = CODE_W'(MAX_CODE);
  localparam logic [CODE_W-1:0] INIT = CODE_W'(RST_CODE);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= INIT;
    end else if (adv) begin
      if (up && cnt != TOP)
        cnt <= cnt + CODE_W'(1);
      else if (!up && cnt != '0)
        cnt <= cnt - CODE_W'(1);
    end
  end

  assert_step_one_R2: assert property (@(posedge clk) disable iff (rst)
    adv |=> ((cnt == $past(cnt) + CODE_W'(1)) || (cnt + CODE_W'(1) == $past(cnt)) ||
             (cnt == $past(cnt))));
  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
    cnt <= TOP);
  assert_hold_top_R3: assert property (@(posedge clk) disable iff (rst)
    (adv && up && cnt == TOP) |=> cnt == TOP);
  assert_hold_zero_R3: assert property (@(posedge clk) disable iff (rst)
    (adv && !up && cnt == '0) |=> cnt == '0);
  assert_frozen_R9: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(cnt));
endmodule

// File: rtl/cl_turn_detect.sv
module cl_turn_detect
  import coarse_lock_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  adv,
  input  logic  sign_up,
  output turn_t turn
);
  logic prev_up;
  logic prev_vld;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_up  <= 1'b0;
      prev_vld <= 1'b0;
    end else if (adv) begin
      prev_up  <= sign_up;
      prev_vld <= 1'b1;
    end
  end

  always_comb begin
    turn.peak   = adv && prev_vld &&  prev_up && !sign_up;
    turn.trough = adv && prev_vld && !prev_up &&  sign_up;
  end

  assert_no_turn_frozen_R9: assert property (@(posedge clk) disable iff (rst)
    !adv |-> (turn == '0));
endmodule

// File: rtl/cl_extreme_store.sv
module cl_extreme_store #(
  parameter int CODE_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stb,
  input  logic [CODE_W-1:0] value,
  output logic [CODE_W-1:0] newest,
  output logic [CODE_W-1:0] older,
  output logic              full
);
  logic [1:0] seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      newest <= '0;
      older  <= '0;
      seen   <= 2'd0;
    end else if (stb) begin
      newest <= value;
      older  <= newest;
      if (seen != 2'd2)
        seen <= seen + 2'd1;
    end
  end

  assign full = (seen == 2'd2);

  assert_capture_value_R4: assert property (@(posedge clk) disable iff (rst)
    stb |=> newest == $past(value));
  assert_keep_pair_R5: assert property (@(posedge clk) disable iff (rst)
    stb |=> older == $past(newest));
  assert_idle_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !stb |=> ($stable(newest) && $stable(older)));
  assert_full_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    full |=> full);
endmodule

// File: rtl/cl_lock_judge.sv
module cl_lock_judge
  import coarse_lock_pkg::*;
#(
  parameter int CODE_W   = 5,
  parameter int LOCK_WIN = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] pk_new,
  input  logic [CODE_W-1:0] pk_old,
  input  logic              pk_full,
  input  logic [CODE_W-1:0] tr_new,
  input  logic [CODE_W-1:0] tr_old,
  input  logic              tr_full,
  output logic              fine_en,
  output logic [CODE_W-1:0] lock_code
);
  logic          close_hit;
  logic [CODE_W:0] mid_sum;

  always_comb begin
    close_hit = pk_full && tr_full &&
                ((code_gap(32'(pk_new), 32'(pk_old)) <= LOCK_WIN) ||
                 (code_gap(32'(tr_new), 32'(tr_old)) <= LOCK_WIN));
    mid_sum   = {1'b0, pk_new} + {1'b0, tr_new};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fine_en   <= 1'b0;
      lock_code <= '0;
    end else if (!fine_en && close_hit) begin
      fine_en   <= 1'b1;
      lock_code <= mid_sum[CODE_W:1];
    end
  end

  assert_need_pairs_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(fine_en) |-> $past(pk_full && tr_full));
  assert_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    fine_en |=> (fine_en && $stable(lock_code)));
  assert_mid_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(fine_en) |-> ({1'b0, lock_code} ==
                        (({1'b0, $past(pk_new)} + {1'b0, $past(tr_new)}) >> 1)));
endmodule

// File: rtl/coarse_lock_ctrl.sv
module coarse_lock_ctrl
  import coarse_lock_pkg::*;
#(
  parameter int MAX_CODE = 24,
  parameter int COL_W    = 3,
  parameter int LOCK_WIN = 2,
  parameter int CODE_W   = $clog2(MAX_CODE + 1),
  parameter int ROW_W    = CODE_W - COL_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sign_up,
  output logic             fine_en,
  output logic [ROW_W-1:0] row_sel,
  output logic [COL_W-1:0] col_sel
);
  localparam int MID_CODE = MAX_CODE / 2;

  logic              adv;
  logic [CODE_W-1:0] cnt;
  turn_t             turn;
  logic [CODE_W-1:0] ext_new [2];
  logic [CODE_W-1:0] ext_old [2];
  logic              ext_full [2];
  logic [1:0]        ext_stb;
  logic [CODE_W-1:0] lock_code;
  logic [CODE_W-1:0] code_sel;

  assign adv     = !fine_en;
  assign ext_stb = {turn.trough, turn.peak};

  cl_step_counter #(
    .MAX_CODE(MAX_CODE), .CODE_W(CODE_W), .RST_CODE(MID_CODE)
  ) u_cnt (
    .clk(clk), .rst(rst), .adv(adv), .up(sign_up), .cnt(cnt)
  );

  cl_turn_detect u_turn (
    .clk(clk), .rst(rst), .adv(adv), .sign_up(sign_up), .turn(turn)
  );

  // index 0 holds peaks, index 1 holds troughs
  for (genvar g = 0; g < 2; g++) begin : g_ext
    cl_extreme_store #(.CODE_W(CODE_W)) u_store (
      .clk(clk), .rst(rst), .stb(ext_stb[g]), .value(cnt),
      .newest(ext_new[g]), .older(ext_old[g]), .full(ext_full[g])
    );
  end

  cl_lock_judge #(.CODE_W(CODE_W), .LOCK_WIN(LOCK_WIN)) u_judge (
    .clk(clk), .rst(rst),
    .pk_new(ext_new[0]), .pk_old(ext_old[0]), .pk_full(ext_full[0]),
    .tr_new(ext_new[1]), .tr_old(ext_old[1]), .tr_full(ext_full[1]),
    .fine_en(fine_en), .lock_code(lock_code)
  );

  assign code_sel = fine_en ? lock_code : cnt;
  assign row_sel  = code_sel[CODE_W-1:COL_W];
  assign col_sel  = code_sel[COL_W-1:0];

  assert_out_range_R3: assert property (@(posedge clk) disable iff (rst)
    code_sel <= CODE_W'(MAX_CODE));
  assert_out_hold_R9: assert property (@(posedge clk) disable iff (rst)
    fine_en |=> ($stable(row_sel) && $stable(col_sel)));
  assert_reset_mid_R1: assert property (@(posedge clk)
    rst |=> (!fine_en && code_sel == CODE_W'(MID_CODE)));
endmodule

// File: tb/sim_coarse_lock_ctrl.sv
module sim_coarse_lock_ctrl;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sign_up = 1'b0;
  logic fine_en;
  logic [1:0] row_sel;
  logic [2:0] col_sel;

  int checks = 0;
  int errors = 0;
  string phase = "R1";

  // behavioural reference state
  int m_code, m_cnt, m_lock;
  bit m_fe, m_prev, m_pvld;
  int pkq[$];
  int trq[$];

  always #5 clk = ~clk;

  coarse_lock_ctrl u0 (
    .clk(clk), .rst(rst), .sign_up(sign_up),
    .fine_en(fine_en), .row_sel(row_sel), .col_sel(col_sel)
  );

  function automatic int gap(int a, int b);
    return (a > b) ? a - b : b - a;
  endfunction

  task automatic model_edge(bit r, bit s);
    if (r) begin
      m_cnt = 12; m_fe = 0; m_pvld = 0; m_prev = 0;
      pkq.delete(); trq.delete();
    end else if (!m_fe) begin
      if (pkq.size() == 2 && trq.size() == 2 &&
          (gap(pkq[0], pkq[1]) <= 2 || gap(trq[0], trq[1]) <= 2)) begin
        m_fe = 1;
        m_lock = (pkq[1] + trq[1]) / 2;
      end else begin
        if (m_pvld && m_prev && !s) begin
          pkq.push_back(m_cnt);
          if (pkq.size() > 2) void'(pkq.pop_front());
        end
        if (m_pvld && !m_prev && s) begin
          trq.push_back(m_cnt);
          if (trq.size() > 2) void'(trq.pop_front());
        end
        m_prev = s; m_pvld = 1;
        if (s && m_cnt < 24) m_cnt++;
        else if (!s && m_cnt > 0) m_cnt--;
      end
    end
    m_code = m_fe ? m_lock : m_cnt;
  endtask

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    check({phase, " R7 fine_en"}, int'(fine_en), int'(m_fe));
    check({phase, " R10 row"}, int'(row_sel), m_code >> 3);
    check({phase, " R10 col"}, int'(col_sel), m_code & 7);
  endtask

  task automatic step(bit r, bit s);
    rst = r; sign_up = s;
    @(posedge clk);
    model_edge(r, s);
    @(negedge clk);
    compare_all();
  endtask

  task automatic run(bit s, int n);
    for (int i = 0; i < n; i++) step(1'b0, s);
  endtask

  task automatic do_reset();
    step(1'b1, 1'b0);
    step(1'b1, 1'b1);
  endtask

  function automatic int port_code();
    return int'(row_sel) * 8 + int'(col_sel);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    // R1: reset state
    phase = "R1";
    do_reset();
    check("R1 code after reset", port_code(), 12);
    check("R1 fine_en after reset", int'(fine_en), 0);

    // R2 / R3: ramp up into the top, then down to the floor
    phase = "R2";
    run(1'b1, 3);
    check("R2 up steps", port_code(), 15);
    phase = "R3 top";
    run(1'b1, 15);
    check("R3 saturate top", port_code(), 24);
    phase = "R3 floor";
    run(1'b0, 30);
    check("R3 saturate floor", port_code(), 0);

    // R6/R8/R9: symmetric limit cycle, peaks 16,16, troughs 12,12
    phase = "R6";
    do_reset();
    run(1'b1, 4); run(1'b0, 4); run(1'b1, 4); run(1'b0, 4);
    check("R6 no lock with one trough", int'(fine_en), 0);
    step(1'b0, 1'b1);         // second trough captured here
    check("R6 still coarse on capture edge", int'(fine_en), 0);
    phase = "R8";
    step(1'b0, 1'b1);         // lock edge
    check("R7 lock one edge after capture", int'(fine_en), 1);
    check("R8 midpoint 14", port_code(), 14);
    phase = "R9";
    for (int i = 0; i < 12; i++) step(1'b0, i[0]);
    check("R9 code frozen", port_code(), 14);
    check("R9 fine_en held", int'(fine_en), 1);

    // R7 boundary / R4 / R5: gaps of 3 must not lock, newest values used
    phase = "R7 gap3";
    do_reset();
    run(1'b1, 4);   // 16
    run(1'b0, 4);   // peak 16 -> 12
    run(1'b1, 7);   // trough 12 -> 19
    run(1'b0, 10);  // peak 19 -> 9
    run(1'b1, 3);   // trough 9, gaps 3 and 3
    check("R7 gap of 3 no lock", int'(fine_en), 0);
    phase = "R5";
    run(1'b1, 6);   // reaches 18
    step(1'b0, 1'b0); // peak 18, oldest peak 16 dropped
    check("R5 still coarse on capture edge", int'(fine_en), 0);
    step(1'b0, 1'b0);
    check("R4 lock from peaks 19,18", int'(fine_en), 1);
    check("R8 midpoint of 18 and 9", port_code(), 13);

    // random hunting, with swings that may hit both ends
    phase = "R2 random";
    for (int k = 0; k < 40; k++) begin
      bit dir;
      do_reset();
      dir = 1'($urandom_range(0, 1));
      for (int j = 0; j < 30; j++) begin
        run(dir, int'($urandom_range(1, 9)));
        dir = !dir;
      end
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule